// File: doc/BRIEF.md
# Interrupt redirection controller with remote-IRR handshake

This block routes a fixed set of interrupt input lines to processors. Each line owns a 64-bit redirection entry that sets the vector, the destination, the addressing and delivery modes, the trigger type and a mask. Software reaches an entry in two steps. It first writes a selector register. It then reads or writes the 32-bit data window, which shows one half of the chosen entry.

A rising edge on an edge-triggered line yields one delivery message for every edge. A level-triggered line delivers once and then sets its remote-IRR bit. While that bit is set, the line stays silent. An end-of-interrupt (EOI) carrying the entry's vector clears the bit. If the line is still high, the EOI re-arms the bit and delivers again. A write that unmasks a line whose input is still high also delivers at once. A delivery is a one-cycle message on the output. Deliveries that become due together leave one per cycle, lowest pin first.

Top module: `intr_redirect`

## Requirements
- R1: After reset every entry's lower half reads 0x0001_0000 (only mask bit 16 set), every upper half reads 0, and no message or error pulse appears.
- R2: A selector value S of 0x10 or more picks entry (S-0x10)>>1, where an even S gives bits 31:0 and an odd S gives bits 63:32. A selector below 0x10 or beyond the last entry reads 0, and writing to it changes no entry.
- R3: A window write to an upper half replaces bits 63:32 (destination ID in 63:56) and leaves bits 31:0 unchanged.
- R4: A window write to a lower half replaces bits 31:0, except that remote-IRR (bit 14) keeps its value and delivery status (bit 12) is not stored. Bit 12 reads 1 only while a delivery for that pin is waiting to be issued.
- R5: A rising edge on a pin whose mask bit is 1 produces neither a message nor an error pulse.
- R6: Each rising edge on an unmasked edge-triggered pin (bit 15 = 0) produces a message. The message is visible after the second rising clock edge that follows the input change. It carries vector = bits 7:0, destination = bits 63:56, destination mode = bit 11, delivery mode = bits 10:8 and level flag = bit 15.
- R7: A rising edge on an unmasked level-triggered pin (bit 15 = 1) delivers and sets remote-IRR only when remote-IRR was clear. When remote-IRR is already set, the edge produces nothing.
- R8: An EOI clears remote-IRR of the lowest-numbered entry whose vector matches. If that entry is level-triggered, unmasked and its input is high, remote-IRR is set again and a new message is issued. An EOI that matches no entry changes nothing.
- R9: After a lower-half write that leaves the entry level-triggered and unmasked, with remote-IRR clear and its input high, remote-IRR is set and a message is issued without any new edge.
- R10: Only delivery modes 000 (fixed) and 001 (lowest priority) produce a message. Any other mode produces a one-cycle mode_err pulse in the cycle where the message would have appeared.
- R11: Deliveries that are due at the same time are issued one per cycle, lowest pin first.
- R12: An EOI and a rising edge that reach the same level-triggered pin in the same cycle produce exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 1: the write targets the selector; 0: the write targets the data window |
| reg_wdata | input | 32 | Write data (the selector uses bits 7:0) |
| reg_rdata | output | 32 | Data window contents for the current selector |
| irq_in | input | NUM_PINS | Active-high interrupt input lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | One-cycle delivery message strobe |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination ID |
| msg_dest_mode | output | 1 | Message destination addressing mode |
| msg_dlv_mode | output | 3 | Message delivery mode |
| msg_level | output | 1 | 1 when the source pin is level-triggered |
| mode_err | output | 1 | One-cycle pulse when a delivery was dropped for an unsupported mode |

## Verification
Two sources can want the same level-triggered pin in one cycle: an EOI that clears its remote-IRR, and a fresh rising edge on its input. The bench first leaves remote-IRR set and drops the line for a cycle. It then raises the line and presents the matching EOI on the same clock edge. The check passes only if exactly one message with the entry's vector appears and the following cycle is quiet. A second collision arises when two edge pins rise together. The bench judges it by the order of the two messages and by the delivery-status bit of the waiting pin, read through the data window while that pin waits.

// File: rtl/intr_redirect_pkg.sv
package intr_redirect_pkg;

    // First selector value that maps onto the redirection table.
    localparam logic [7:0] SEL_BASE = 8'h10;

    localparam logic [2:0] DLV_FIXED  = 3'b000;
    localparam logic [2:0] DLV_LOWEST = 3'b001;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // One 64-bit redirection entry, MSB first.
    typedef struct packed {
        logic [7:0]  dest;      // 63:56
        logic [23:0] spare_hi;  // 55:32
        logic [14:0] spare_lo;  // 31:17
        logic        mask;      // 16
        trig_e       trig;      // 15
        logic        rirr;      // 14
        logic        pol;       // 13
        logic        dstat;     // 12
        logic        dst_mode;  // 11
        logic [2:0]  dlv_mode;  // 10:8
        logic [7:0]  vector;    // 7:0
    } redir_t;

    // Fields carried by one outgoing delivery message.
    typedef struct packed {
        logic [7:0] vector;
        logic [7:0] dest;
        logic       dst_mode;
        logic [2:0] dlv_mode;
        logic       level;
    } msg_t;

    function automatic redir_t entry_reset();
        redir_t e;
        e = '0;
        e.mask = 1'b1;
        return e;
    endfunction

    // Lower-half write: status bits are not writable by software.
    function automatic redir_t merge_lower(redir_t old, logic [31:0] w);
        redir_t e;
        e = {old[63:32], w};
        e.dstat = 1'b0;
        e.rirr  = old.rirr;
        return e;
    endfunction

    function automatic redir_t merge_upper(redir_t old, logic [31:0] w);
        redir_t e;
        e = {w, old[31:0]};
        return e;
    endfunction

    function automatic logic mode_ok(logic [2:0] m);
        return (m == DLV_FIXED) || (m == DLV_LOWEST);
    endfunction

endpackage

// File: rtl/ir_sel_decode.sv
module ir_sel_decode
    import intr_redirect_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_we,
    input  logic [7:0]          sel_wdata,
    input  logic                data_we,
    output logic [NUM_PINS-1:0] wr_lo,
    output logic [NUM_PINS-1:0] wr_hi,
    output logic [IDX_W-1:0]    rd_idx,
    output logic                rd_upper,
    output logic                rd_valid
);

    localparam logic [6:0] PINS7 = 7'(NUM_PINS);

    logic [7:0] sel_q;
    logic [7:0] off;
    logic [6:0] ent_num;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (sel_we)
            sel_q <= sel_wdata;
    end

    assign off      = sel_q - SEL_BASE;
    assign ent_num  = off[7:1];
    assign rd_valid = (sel_q >= SEL_BASE) && (ent_num < PINS7);
    assign rd_upper = off[0];
    assign rd_idx   = ent_num[IDX_W-1:0];

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_wr
        assign wr_lo[gi] = data_we && rd_valid && (ent_num == 7'(gi)) && !off[0];
        assign wr_hi[gi] = data_we && rd_valid && (ent_num == 7'(gi)) &&  off[0];
    end

endmodule

// File: rtl/ir_edge_detect.sv
module ir_edge_detect #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] lines,
    output logic [NUM_PINS-1:0] rise
);

    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else
            prev_q <= lines;
    end

    assign rise = lines & ~prev_q;

endmodule

// File: rtl/ir_eoi_match.sv
module ir_eoi_match #(
    parameter int NUM_PINS = 8
) (
    input  logic                     eoi_valid,
    input  logic [7:0]               eoi_vector,
    input  logic [NUM_PINS-1:0][7:0] vectors,
    output logic [NUM_PINS-1:0]      hit
);

    // Lowest-numbered matching entry takes the EOI.
    always_comb begin
        logic found;
        found = 1'b0;
        hit   = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (eoi_valid && !found && (vectors[i] == eoi_vector)) begin
                hit[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ir_issue.sv
module ir_issue
    import intr_redirect_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pending,
    input  msg_t                cand [NUM_PINS],
    output logic [NUM_PINS-1:0] grant,
    output logic                out_valid,
    output logic                out_err,
    output msg_t                out_msg
);

    logic [IDX_W-1:0] pick;
    logic             any;

    always_comb begin
        grant = '0;
        pick  = '0;
        any   = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pending[i] && !any) begin
                grant[i] = 1'b1;
                pick     = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_msg   <= '0;
        end else begin
            out_valid <= any &&  mode_ok(cand[pick].dlv_mode);
            out_err   <= any && !mode_ok(cand[pick].dlv_mode);
            if (any)
                out_msg <= cand[pick];
        end
    end

endmodule

// File: rtl/intr_redirect.sv
module intr_redirect
    import intr_redirect_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic                reg_wr_sel,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    output logic [7:0]          msg_vector,
    output logic [7:0]          msg_dest,
    output logic                msg_dest_mode,
    output logic [2:0]          msg_dlv_mode,
    output logic                msg_level,
    output logic                mode_err
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0]      wr_lo, wr_hi, rise, eoi_hit, fire_vec, grant;
    logic [NUM_PINS-1:0]      pending_q, rirr_vec;
    logic [NUM_PINS-1:0][7:0] vec_list;
    logic [IDX_W-1:0]         rd_idx;
    logic                     rd_upper, rd_valid;
    redir_t                   entries [NUM_PINS];
    msg_t                     cand    [NUM_PINS];
    msg_t                     msg_q;

    ir_sel_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .sel_we   (reg_wr_en && reg_wr_sel),
        .sel_wdata(reg_wdata[7:0]),
        .data_we  (reg_wr_en && !reg_wr_sel),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .rd_idx   (rd_idx),
        .rd_upper (rd_upper),
        .rd_valid (rd_valid)
    );

    ir_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lines(irq_in),
        .rise (rise)
    );

    ir_eoi_match #(.NUM_PINS(NUM_PINS)) u_eoi (
        .eoi_valid (eoi_valid),
        .eoi_vector(eoi_vector),
        .vectors   (vec_list),
        .hit       (eoi_hit)
    );

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        redir_t ent_q, wrote, nxt;
        logic   rirr_mid, fire;

        always_comb begin
            wrote = ent_q;
            if (wr_lo[gi])
                wrote = merge_lower(ent_q, reg_wdata);
            else if (wr_hi[gi])
                wrote = merge_upper(ent_q, reg_wdata);

            // EOI clears remote-IRR before any re-arm is considered.
            rirr_mid = eoi_hit[gi] ? 1'b0 : ent_q.rirr;
            nxt      = wrote;
            nxt.rirr = rirr_mid;
            fire     = 1'b0;

            if (!wrote.mask) begin
                if (wrote.trig == TRIG_EDGE) begin
                    fire = rise[gi];
                end else if (!rirr_mid && irq_in[gi] &&
                             (rise[gi] || eoi_hit[gi] || wr_lo[gi])) begin
                    fire     = 1'b1;
                    nxt.rirr = 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= entry_reset();
            else
                ent_q <= nxt;
        end

        assign entries[gi]  = ent_q;
        assign vec_list[gi] = ent_q.vector;
        assign fire_vec[gi] = fire;
        assign rirr_vec[gi] = ent_q.rirr;
        assign cand[gi]     = '{vector:   ent_q.vector,
                                dest:     ent_q.dest,
                                dst_mode: ent_q.dst_mode,
                                dlv_mode: ent_q.dlv_mode,
                                level:    (ent_q.trig == TRIG_LEVEL)};
    end

    always_ff @(posedge clk) begin
        if (rst)
            pending_q <= '0;
        else
            pending_q <= (pending_q & ~grant) | fire_vec;
    end

    ir_issue #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .pending  (pending_q),
        .cand     (cand),
        .grant    (grant),
        .out_valid(msg_valid),
        .out_err  (mode_err),
        .out_msg  (msg_q)
    );

    // Data window: delivery status shows a waiting delivery.
    always_comb begin
        logic [63:0] shown;
        shown     = entries[rd_idx];
        shown[12] = shown[12] | pending_q[rd_idx];
        if (!rd_valid)
            reg_rdata = '0;
        else if (rd_upper)
            reg_rdata = shown[63:32];
        else
            reg_rdata = shown[31:0];
    end

    assign msg_vector    = msg_q.vector;
    assign msg_dest      = msg_q.dest;
    assign msg_dest_mode = msg_q.dst_mode;
    assign msg_dlv_mode  = msg_q.dlv_mode;
    assign msg_level     = msg_q.level;

endmodule

// File: rtl/ir_checker.sv
module ir_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                msg_valid,
    input logic                mode_err,
    input logic [2:0]          msg_dlv_mode,
    input logic [NUM_PINS-1:0] pending,
    input logic [NUM_PINS-1:0] rirr
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (pending == '0) && !msg_valid && !mode_err);

    // R10
    mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_dlv_mode <= 3'd1));

    // R10
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(msg_valid && mode_err));

    // R11
    drain_progress_chk: assert property (@(posedge clk) disable iff (rst)
        (pending != '0) |=> (msg_valid || mode_err));

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        // R7
        rirr_fire_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(rirr[gi]) |-> pending[gi]);
    end

endmodule

bind intr_redirect ir_checker #(.NUM_PINS(NUM_PINS)) u_ir_checker (
    .clk         (clk),
    .rst         (rst),
    .msg_valid   (msg_valid),
    .mode_err    (mode_err),
    .msg_dlv_mode(msg_dlv_mode),
    .pending     (pending_q),
    .rirr        (rirr_vec)
);

// File: tb/test_intr_redirect.sv
module test_intr_redirect;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_in = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid, msg_dest_mode, msg_level, mode_err;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_dlv_mode;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    intr_redirect #(.NUM_PINS(N)) i_intr_redirect (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_dest(msg_dest),
        .msg_dest_mode(msg_dest_mode), .msg_dlv_mode(msg_dlv_mode),
        .msg_level(msg_level), .mode_err(mode_err)
    );

    // Row: pin[68:66], lower[65:34], upper[33:2], exp_valid[1], exp_err[0]
    localparam logic [5:0][68:0] TBL = {
        {3'd5, 32'h0000_0780, 32'h0400_0000, 1'b0, 1'b1},  // R10 mode 111
        {3'd4, 32'h0000_8071, 32'h0300_0000, 1'b1, 1'b0},  // R7 level
        {3'd3, 32'h0000_0260, 32'h0200_0000, 1'b0, 1'b1},  // R10 mode 010
        {3'd2, 32'h0001_0050, 32'h0100_0000, 1'b0, 1'b0},  // R5 masked
        {3'd1, 32'h0000_0942, 32'hA000_0000, 1'b1, 1'b0},  // R6 lowest prio
        {3'd0, 32'h0000_0031, 32'h0500_0000, 1'b1, 1'b0}   // R6 fixed
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sel(input logic [7:0] s);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wdata = {24'd0, s};
        step();
        reg_wr_en = 1'b0; reg_wr_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] s, input logic [31:0] d);
        set_sel(s);
        reg_wr_en = 1'b1; reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] s, output logic [31:0] v);
        set_sel(s);
        v = reg_rdata;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        step();
        eoi_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        step(3);
        rst = 1'b0;
        step();

        // R1 reset state
        rd(8'h10, v); check("R1 lower after reset", v, 32'h0001_0000);
        rd(8'h1F, v); check("R1 upper after reset", v, 32'h0);
        check("R1 no message", {msg_valid, mode_err}, 2'b00);

        // Table walk: program, raise one pin, judge the message.
        for (int r = 0; r < 6; r++) begin
            logic [2:0]  pin;
            logic [31:0] lo, hi;
            pin = TBL[r][68:66];
            lo  = TBL[r][65:34];
            hi  = TBL[r][33:2];
            wr(8'h10 + {4'd0, pin, 1'b1}, hi);
            wr(8'h10 + {4'd0, pin, 1'b0}, lo);
            irq_in[pin] = 1'b1;
            step(2);
            check("R5 R6 R7 R10 table valid", msg_valid, TBL[r][1]);
            check("R10 table error", mode_err, TBL[r][0]);
            if (TBL[r][1]) begin
                check("R6 message fields", {msg_vector, msg_dest, msg_dest_mode, msg_dlv_mode, msg_level},
                      {lo[7:0], hi[31:24], lo[11], lo[10:8], lo[15]});
            end
            irq_in[pin] = 1'b0;
            step();
        end

        // R6 second edge on an edge pin delivers again
        irq_in[0] = 1'b1; step(2);
        check("R6 repeat edge", {msg_valid, msg_vector}, {1'b1, 8'h31});
        irq_in[0] = 1'b0; step();

        // R7 remote-IRR set blocks a new edge
        rd(8'h18, v); check("R7 remote-IRR set", v, 32'h0000_C071);
        irq_in[4] = 1'b1; step(2);
        check("R7 blocked edge", msg_valid, 1'b0);
        irq_in[4] = 1'b0; step();

        // R8 EOI with the line low only clears remote-IRR
        eoi(8'h71); step();
        check("R8 EOI line low no message", msg_valid, 1'b0);
        rd(8'h18, v); check("R8 remote-IRR cleared", v, 32'h0000_8071);
        irq_in[4] = 1'b1; step(2);
        check("R7 edge after clear", {msg_valid, msg_vector, msg_level}, {1'b1, 8'h71, 1'b1});
        step();
        // R8 EOI with the line still high re-delivers
        eoi(8'h71); step();
        check("R8 EOI redelivery", {msg_valid, msg_vector}, {1'b1, 8'h71});
        step();

        // R8 unmatched EOI changes nothing
        eoi(8'hEE); step();
        check("R8 unmatched EOI no message", msg_valid, 1'b0);
        rd(8'h18, v); check("R8 unmatched EOI keeps remote-IRR", v, 32'h0000_C071);

        // R5 and R9: masked level pin, then unmask while high
        wr(8'h1C, 32'h0001_8090);
        irq_in[6] = 1'b1; step(2);
        check("R5 masked level edge", {msg_valid, mode_err}, 2'b00);
        wr(8'h1C, 32'h0000_8090); step();
        check("R9 unmask redelivery", {msg_valid, msg_vector}, {1'b1, 8'h90});
        rd(8'h1C, v); check("R9 remote-IRR set by write", v, 32'h0000_C090);
        wr(8'h1C, 32'h0000_9090); step();
        check("R9 no redelivery with remote-IRR set", msg_valid, 1'b0);
        rd(8'h1C, v); check("R4 status bits not writable", v, 32'h0000_C090);

        // R3 upper write leaves lower half alone
        wr(8'h1D, 32'h1234_5678);
        rd(8'h1D, v); check("R3 upper written", v, 32'h1234_5678);
        rd(8'h1C, v); check("R3 lower unchanged", v, 32'h0000_C090);

        // R2 selector mapping and out-of-range access
        rd(8'h0F, v); check("R2 below base reads zero", v, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); check("R2 beyond table reads zero", v, 32'h0);
        rd(8'h10, v); check("R2 pin0 lower unaffected", v, 32'h0000_0031);
        rd(8'h11, v); check("R2 odd selector upper half", v, 32'h0500_0000);

        // R11 and R4: two edge pins rise together
        set_sel(8'h12);
        irq_in[0] = 1'b1; irq_in[1] = 1'b1;
        step();
        check("R4 delivery status while waiting", reg_rdata, 32'h0000_1942);
        step();
        check("R11 lowest pin first", {msg_valid, msg_vector}, {1'b1, 8'h31});
        check("R4 still waiting", reg_rdata, 32'h0000_1942);
        step();
        check("R11 second pin next cycle", {msg_valid, msg_vector}, {1'b1, 8'h42});
        check("R4 status cleared after issue", reg_rdata, 32'h0000_0942);
        irq_in[0] = 1'b0; irq_in[1] = 1'b0;
        step();

        // R12 EOI and rising edge in the same cycle on pin 4
        irq_in[4] = 1'b0; step();
        irq_in[4] = 1'b1; eoi_valid = 1'b1; eoi_vector = 8'h71;
        step();
        eoi_valid = 1'b0;
        step();
        check("R12 single delivery", {msg_valid, msg_vector}, {1'b1, 8'h71});
        step();
        check("R12 no second delivery", msg_valid, 1'b0);

        // R1 reset in mid-run
        rst = 1'b1; step(2); rst = 1'b0; step();
        rd(8'h1C, v); check("R1 lower after second reset", v, 32'h0001_0000);
        rd(8'h1D, v); check("R1 upper after second reset", v, 32'h0);
        step();
        check("R1 quiet after second reset", {msg_valid, mode_err}, 2'b00);

        finish_run();
    end

endmodule